// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block handles the housekeeping of an asynchronous DRAM array. After reset it keeps the RAS, CAS and write strobes idle for a fixed power-up pause. It then issues a burst of CAS-before-RAS refresh cycles to initialize the array, and only after that burst does it raise `init_done`, which lets the access sequencer start issuing traffic.

In normal operation a free-running interval counter creates one refresh obligation per interval, so that every row is refreshed inside the retention window. Obligations accumulate up to a fixed limit while the request waits for the access sequencer's grant. Once granted, the block drives the strobes itself and runs the owed cycles back to back.

The write strobe stays high through every refresh, so the memory never mistakes a refresh for the test-mode entry sequence. If no refresh cycle completes for longer than the retention window, the block drops `init_done` and repeats the full initialization burst under grant.

Top module: `dref_sched`

## Requirements
- R1: While reset is asserted and for PAUSE_CYC cycles after it is released, `ras_n`, `cas_n` and `we_n` stay high, and `init_done` and `ref_req` stay low. The first CAS fall appears between PAUSE_CYC and PAUSE_CYC+2 cycles after reset release.
- R2: After the pause, exactly INIT_CYCLES refresh cycles are issued without a grant and with `ref_req` low. `init_done` rises only after the last of these cycles has finished its precharge, with both strobes high.
- R3: In every refresh cycle `cas_n` is low for at least T_CSR cycles before `ras_n` falls, and it stays low until `ras_n` rises again.
- R4: `we_n` is high at every RAS fall, and at all other times, so refresh never takes the test-mode ordering.
- R5: `ras_n` stays low for at least T_RAS cycles in each refresh. Between two RAS falls it is high for at least T_RP+T_CSR cycles.
- R6: After initialization, one refresh becomes owed every REFI_CYC cycles. `ref_req` is high whenever a refresh is owed or a cycle is in progress, and `ras_n` never falls while `ref_req` is low and `init_done` is high.
- R7: Owed refreshes accumulate up to MAX_OWED while the grant is withheld. Once granted, they are issued back to back, with RAS falls spaced exactly T_CSR+T_RAS+T_RP cycles apart. `ref_req` falls after the last one.
- R8: A raised request stays raised until it is granted.
- R9: If no refresh cycle completes for LAPSE_CYC cycles, `init_done` falls and `ref_req` rises. INIT_CYCLES refresh cycles are then issued under grant before `init_done` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Access sequencer hands the strobes to this block |
| ref_req | output | 1 | Block needs the strobes for refresh or re-initialization |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| init_done | output | 1 | Array initialized, accesses may proceed |

## Verification
The bound checker watches the strobe ordering on every cycle: CAS leads RAS and stays low while RAS is low, and the minimum RAS-low and precharge widths hold. It also checks that no RAS activity happens without a request after initialization, and that `init_done` only rises with the strobes idle. The scenarios show what a single cycle cannot: the pause length, the exact count of initialization cycles, saturation of the owed count under withheld grants, back-to-back spacing within a burst, and the lapse that forces re-initialization.

// File: rtl/dref_pkg.sv
package dref_pkg;
    typedef enum logic [1:0] {PH_PAUSE, PH_INIT, PH_REINIT, PH_RUN} phase_e;
    typedef enum logic [1:0] {SQ_IDLE, SQ_SETUP, SQ_LOW, SQ_PRE} seq_e;
endpackage

// File: rtl/dref_strobe_seq.sv
module dref_strobe_seq
    import dref_pkg::*;
#(
    parameter int T_CSR = 2,
    parameter int T_RAS = 10,
    parameter int T_RP  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic ras_n,
    output logic cas_n
);
    localparam int TMAX = (T_RAS > T_CSR) ? ((T_RAS > T_RP) ? T_RAS : T_RP)
                                          : ((T_CSR > T_RP) ? T_CSR : T_RP);
    localparam int TW = $clog2(TMAX + 1);

    typedef struct packed {
        seq_e          st;
        logic [TW-1:0] tmr;
        logic          ras_n;
        logic          cas_n;
    } seq_t;

    seq_t q, d;
    logic fin;

    always_comb begin
        d   = q;
        fin = (q.st == SQ_PRE) && (q.tmr == '0);
        case (q.st)
            SQ_IDLE: if (start) begin
                d.st  = SQ_SETUP;
                d.tmr = TW'(T_CSR - 1);
            end
            SQ_SETUP: if (q.tmr == '0) begin
                d.st  = SQ_LOW;
                d.tmr = TW'(T_RAS - 1);
            end else d.tmr = q.tmr - TW'(1);
            SQ_LOW: if (q.tmr == '0) begin
                d.st  = SQ_PRE;
                d.tmr = TW'(T_RP - 1);
            end else d.tmr = q.tmr - TW'(1);
            default: if (q.tmr == '0) begin
                if (start) begin
                    d.st  = SQ_SETUP;
                    d.tmr = TW'(T_CSR - 1);
                end else d.st = SQ_IDLE;
            end else d.tmr = q.tmr - TW'(1);
        endcase
        d.cas_n = !((d.st == SQ_SETUP) || (d.st == SQ_LOW));
        d.ras_n = !(d.st == SQ_LOW);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: SQ_IDLE, tmr: '0, ras_n: 1'b1, cas_n: 1'b1};
        else        q <= d;
    end

    assign busy  = (q.st != SQ_IDLE);
    assign done  = fin;
    assign ras_n = q.ras_n;
    assign cas_n = q.cas_n;
endmodule

// File: rtl/dref_tick.sv
module dref_tick #(
    parameter int REFI_CYC = 3120,
    parameter int MAX_OWED = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en,
    input  logic                          take,
    output logic [$clog2(MAX_OWED+1)-1:0] owed
);
    localparam int IW = $clog2(REFI_CYC);
    localparam int OW = $clog2(MAX_OWED + 1);

    typedef struct packed {
        logic [IW-1:0] ivl;
        logic [OW-1:0] owed;
    } tick_t;

    tick_t q, d;
    logic  wrap;

    always_comb begin
        d    = q;
        wrap = (q.ivl == IW'(REFI_CYC - 1));
        if (!en) begin
            d.ivl  = '0;
            d.owed = '0;
        end else begin
            d.ivl = wrap ? '0 : q.ivl + IW'(1);
            if (take && q.owed != '0) d.owed = q.owed - OW'(1);
            if (wrap && d.owed != OW'(MAX_OWED)) d.owed = d.owed + OW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign owed = q.owed;
endmodule

// File: rtl/dref_lapse.sv
module dref_lapse #(
    parameter int LAPSE_CYC = 6400000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic kick,
    output logic expired
);
    localparam int LW = $clog2(LAPSE_CYC);

    typedef struct packed {
        logic [LW-1:0] cnt;
    } lapse_t;

    lapse_t q, d;

    always_comb begin
        d = q;
        if (!en || kick)                     d.cnt = '0;
        else if (q.cnt != LW'(LAPSE_CYC - 1)) d.cnt = q.cnt + LW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expired = (q.cnt == LW'(LAPSE_CYC - 1));
endmodule

// File: rtl/dref_sched.sv
module dref_sched
    import dref_pkg::*;
#(
    parameter int PAUSE_CYC   = 100000,
    parameter int INIT_CYCLES = 8,
    parameter int REFI_CYC    = 3120,
    parameter int MAX_OWED    = 4,
    parameter int LAPSE_CYC   = 6400000,
    parameter int T_CSR       = 2,
    parameter int T_RAS       = 10,
    parameter int T_RP        = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic init_done
);
    localparam int PW = $clog2(PAUSE_CYC + 1);
    localparam int BW = $clog2(INIT_CYCLES + 1);
    localparam int OW = $clog2(MAX_OWED + 1);

    typedef struct packed {
        phase_e        ph;
        logic [PW-1:0] wait_cnt;
        logic [BW-1:0] left;
        logic          ready;
    } top_t;

    top_t q, d;
    logic start, take, busy, seq_done, expired, seq_free;
    logic [OW-1:0] owed;

    dref_strobe_seq #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
        .done(seq_done), .ras_n(ras_n), .cas_n(cas_n)
    );

    dref_tick #(.REFI_CYC(REFI_CYC), .MAX_OWED(MAX_OWED)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(q.ph == PH_RUN), .take(take), .owed(owed)
    );

    dref_lapse #(.LAPSE_CYC(LAPSE_CYC)) u_lapse (
        .clk(clk), .rst_n(rst_n), .en(q.ph == PH_RUN), .kick(seq_done),
        .expired(expired)
    );

    always_comb begin
        d        = q;
        start    = 1'b0;
        take     = 1'b0;
        seq_free = !busy || seq_done;
        case (q.ph)
            PH_PAUSE: begin
                if (q.wait_cnt == '0) begin
                    d.ph   = PH_INIT;
                    d.left = BW'(INIT_CYCLES);
                end else d.wait_cnt = q.wait_cnt - PW'(1);
            end
            PH_INIT, PH_REINIT: begin
                if (q.left != '0 && seq_free && (q.ph == PH_INIT || ref_gnt)) begin
                    start  = 1'b1;
                    d.left = q.left - BW'(1);
                end else if (q.left == '0 && seq_done) begin
                    d.ph    = PH_RUN;
                    d.ready = 1'b1;
                end
            end
            default: begin
                if (owed != '0 && ref_gnt && seq_free) begin
                    start = 1'b1;
                    take  = 1'b1;
                end else if (expired && !busy) begin
                    d.ph    = PH_REINIT;
                    d.left  = BW'(INIT_CYCLES);
                    d.ready = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{ph: PH_PAUSE, wait_cnt: PW'(PAUSE_CYC - 1), left: '0, ready: 1'b0};
        else        q <= d;
    end

    assign ref_req   = ((q.ph == PH_RUN) && (owed != '0 || busy)) ||
                       ((q.ph == PH_REINIT) && (q.left != '0 || busy));
    assign we_n      = 1'b1;
    assign init_done = q.ready;
endmodule

// File: rtl/dref_sched_chk.sv
module dref_sched_chk #(
    parameter int T_RAS = 10,
    parameter int T_RP  = 6
) (
    input logic clk,
    input logic rst_n,
    input logic ref_req,
    input logic ras_n,
    input logic cas_n,
    input logic init_done
);
    localparam int CMAX = ((T_RAS > T_RP) ? T_RAS : T_RP) + 1;
    localparam int CW   = $clog2(CMAX + 1);

    logic [CW-1:0] low_cnt, high_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            high_cnt <= CW'(CMAX);
        end else if (!ras_n) begin
            high_cnt <= '0;
            if (low_cnt != CW'(CMAX)) low_cnt <= low_cnt + CW'(1);
        end else begin
            low_cnt <= '0;
            if (high_cnt != CW'(CMAX)) high_cnt <= high_cnt + CW'(1);
        end
    end

    AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(ras_n)) |-> $past(!cas_n));                        // R3
    AST_CAS_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);                                                  // R3
    AST_RAS_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && $past(!ras_n)) |-> (low_cnt >= CW'(T_RAS)));               // R5
    AST_PRECHARGE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(ras_n)) |-> (high_cnt >= CW'(T_RP)));               // R5
    AST_STROBE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && !ras_n) |-> ref_req);                                  // R6
    AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (ras_n && cas_n));                              // R2
endmodule

bind dref_sched dref_sched_chk #(.T_RAS(T_RAS), .T_RP(T_RP)) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ras_n(ras_n),
    .cas_n(cas_n), .init_done(init_done)
);

// File: tb/test_dref_sched.sv
module test_dref_sched;
    localparam int PAUSE = 20, INITN = 8, REFI = 100, MAXO = 3, LAPSE = 800;
    localparam int TCSR = 2, TRAS = 10, TRP = 6;
    localparam int CYC = TCSR + TRAS + TRP;
    localparam int NV = 4;
    // each row: intervals the grant is withheld, refreshes expected once granted
    localparam int VEC [NV][2] = '{'{1, 1}, '{2, 2}, '{3, 3}, '{5, 3}};

    logic clk = 0, rst_n = 0, ref_gnt = 0;
    logic ref_req, ras_n, cas_n, we_n, init_done;
    int tests = 0, fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dref_sched #(.PAUSE_CYC(PAUSE), .INIT_CYCLES(INITN), .REFI_CYC(REFI),
        .MAX_OWED(MAXO), .LAPSE_CYC(LAPSE), .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP))
    i_dref_sched (.clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .init_done(init_done));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // strobe monitor, sampled on the falling edge
    int scnt = 0, falls = 0, last_fall = -1, last_gap = 0;
    int cas_run = 0, low_run = 0, high_run = 1000;
    logic p_ras = 1;
    always @(negedge clk) begin
        scnt++;
        if (rst_n) begin
            if (p_ras && !ras_n) begin
                chk(cas_run >= TCSR, "R3 cas lead", cas_run, TCSR);
                chk(we_n == 1'b1, "R4 we_n at ras fall", int'(we_n), 1);
                chk(high_run >= TRP + TCSR, "R5 ras high gap", high_run, TRP + TCSR);
                falls++;
                if (last_fall >= 0) last_gap = scnt - last_fall;
                last_fall = scnt;
            end
            if (!p_ras && ras_n) begin
                chk(low_run >= TRAS, "R5 ras low width", low_run, TRAS);
                chk(cas_run >= TCSR + TRAS, "R3 cas held", cas_run, TCSR + TRAS);
            end
            cas_run  = cas_n ? 0 : cas_run + 1;
            low_run  = ras_n ? 0 : low_run + 1;
            high_run = ras_n ? high_run + 1 : 0;
            p_ras    = ras_n;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int n, f0, t_rel;
        bit bad;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(ras_n == 1, "R1 ras_n reset", int'(ras_n), 1);
        chk(cas_n == 1, "R1 cas_n reset", int'(cas_n), 1);
        chk(we_n == 1, "R1 we_n reset", int'(we_n), 1);
        chk(init_done == 0, "R1 init_done reset", int'(init_done), 0);
        chk(ref_req == 0, "R1 ref_req reset", int'(ref_req), 0);
        @(posedge clk); #1 rst_n = 1;
        // R1: pause length
        n = 0; bad = 0;
        while (cas_n && n < 1000) begin
            @(negedge clk); n++;
            if (init_done || ref_req || !ras_n) bad = 1;
        end
        chk(n >= PAUSE && n <= PAUSE + 2, "R1 pause length", n, PAUSE + 1);
        chk(!bad, "R1 quiet during pause", int'(bad), 0);
        // R2: initialization burst without grant
        n = 0; bad = 0;
        while (!init_done && n < 1000) begin
            @(negedge clk); n++;
            if (ref_req) bad = 1;
        end
        chk(falls == INITN, "R2 init cycle count", falls, INITN);
        chk(!bad, "R2 no request during init", int'(bad), 0);
        chk(ras_n && cas_n, "R2 strobes idle at init_done", int'(ras_n & cas_n), 1);
        // R6 R7 R8: withheld grants, walked from the table
        for (int v = 0; v < NV; v++) begin
            n = 0;
            while (!ref_req && n < 1000) begin @(negedge clk); n++; end
            chk(ref_req, "R6 request after interval", int'(ref_req), 1);
            bad = 0;
            repeat ((VEC[v][0] - 1) * REFI + 20) begin
                @(negedge clk);
                if (!ref_req) bad = 1;
            end
            chk(!bad, "R8 request held", int'(bad), 0);
            f0 = falls;
            @(posedge clk); #1 ref_gnt = 1;
            n = 0;
            do begin @(negedge clk); n++; end while (ref_req && n < 1000);
            t_rel = scnt;
            @(posedge clk); #1 ref_gnt = 0;
            chk(falls - f0 == VEC[v][1], "R7 owed refreshes issued", falls - f0, VEC[v][1]);
            if (VEC[v][1] >= 2)
                chk(last_gap == CYC, "R7 back-to-back spacing", last_gap, CYC);
        end
        // R9: lapse forces re-initialization under grant
        n = 0;
        while (init_done && n < 3000) begin @(negedge clk); n++; end
        chk(scnt - t_rel >= LAPSE - 1 && scnt - t_rel <= LAPSE + 1,
            "R9 lapse length", scnt - t_rel, LAPSE);
        chk(ref_req == 1, "R9 request on lapse", int'(ref_req), 1);
        f0 = falls;
        @(posedge clk); #1 ref_gnt = 1;
        n = 0;
        while (!init_done && n < 2000) begin @(negedge clk); n++; end
        @(posedge clk); #1 ref_gnt = 0;
        chk(init_done == 1, "R9 init_done back", int'(init_done), 1);
        chk(falls - f0 == INITN, "R9 re-init cycle count", falls - f0, INITN);
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule